// File: doc/BRIEF.md
# Barrel Shift and Rotate Unit with Condition Flags

This block is the shift stage of a 32-bit integer datapath. A single combinational path takes one operand and applies one of five operations to it: arithmetic right shift, logical left shift, logical right shift, rotate right, or a one-place rotate right through the carry. The amount is an 8-bit value, so every count from 0 to 255 has a defined result. The stage also returns the bit that was last shifted out. That bit is the shifter carry.

Next to the result, the unit works out the next value of a four-bit condition-flag word. When flag writing is enabled, the negative, zero and carry flags come from the shift. The overflow flag is always passed through unchanged. When flag writing is disabled, the whole word passes through untouched. An optional register stage, selected by a parameter, holds the flag word and loads it only when flag writing is enabled.

Top module: `shift_flag_unit`

## Requirements
- R1: Logical left shift by an amount from 1 to 31 returns the operand moved left with zeros entering at bit 0. The carry is operand bit (32 - amount). The operation code is 1.
- R2: For operation codes 0 to 3, an amount of 0 returns the operand unchanged, and the carry equals `carry_in`.
- R3: For logical left (code 1) and logical right (code 2), an amount of exactly 32 gives a zero result. The carry is operand bit 0 for the left shift and operand bit 31 for the right shift. Any amount from 33 to 255 gives a zero result with a carry of 0.
- R4: Arithmetic right shift (code 0) fills vacated bits with operand bit 31. For amounts of 32 or more, every result bit and the carry equal operand bit 31.
- R5: Rotate right (code 3) uses the amount modulo 32. For any nonzero amount, the carry equals result bit 31. A nonzero multiple of 32 therefore returns the operand with carry equal to operand bit 31.
- R6: Extended rotate (code 4) ignores the amount. It moves the operand right by one place, places `carry_in` in bit 31, and outputs the old bit 0 as the carry.
- R7: With `set_flags` high, `flags_next` bit 3 (negative) equals result bit 31, bit 2 (zero) is set exactly when the result is all zeros, and bit 1 (carry) equals `shift_carry`.
- R8: `flags_next` bit 0 (overflow) always equals `flags_in` bit 0, whatever the operation or amount.
- R9: With `set_flags` low, `flags_next` equals `flags_in` on all four bits.
- R10: With the register stage enabled (the default), `flags_q` clears to 0 on a clock edge with `rst_n` low. It loads `flags_next` on an edge where `set_flags` is high and holds its value otherwise.
- R11: Logical right shift by an amount from 1 to 31 fills vacated bits with zeros. The carry is operand bit (amount - 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register stage |
| rst_n | input | 1 | Synchronous active-low reset |
| op_sel | input | 3 | Operation: 0 arith right, 1 logical left, 2 logical right, 3 rotate right, 4 extended rotate |
| amount | input | 8 | Shift count, 0 to 255 |
| operand | input | 32 | Value to shift |
| carry_in | input | 1 | Incoming carry: result for zero counts, fill bit for extended rotate |
| set_flags | input | 1 | Enables the flag update |
| flags_in | input | 4 | Current flags {N, Z, C, V} |
| result | output | 32 | Shifted value |
| shift_carry | output | 1 | Last bit shifted out |
| flags_next | output | 4 | Next flags {N, Z, C, V} |
| flags_q | output | 4 | Registered flags, or `flags_next` when the stage is disabled |

## Verification
The assertions sample the combinational outputs on the rising clock edge. They rely on `op_sel`, `amount`, `operand`, `carry_in`, `set_flags` and `flags_in` being steady across that edge, and on `op_sel` carrying one of the five defined codes. The bench changes inputs only on the falling edge and uses only codes 0 to 4. It compares every output against a bit-serial model that shifts one place per count. It puts extra weight on the counts 0, 31, 32, 33, 64 and 255, where the carry rule changes.

// File: rtl/shift_unit_pkg.sv
// Package: shared operation encoding and flag word layout for the shift unit.
// Assumes the flag word is ordered {N, Z, C, V} from bit 3 down to bit 0.
package shift_unit_pkg;

    typedef enum logic [2:0] {
        SH_ASR = 3'd0,
        SH_LSL = 3'd1,
        SH_LSR = 3'd2,
        SH_ROR = 3'd3,
        SH_RRX = 3'd4
    } shift_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } cc_flags_t;

endpackage

// File: rtl/shift_linear.sv
// Module: shift_linear
// Handles the arithmetic right, logical left and logical right shifts for any
// count from 0 to 2**AMT_W-1. It shifts a copy of the operand that is one bit
// wider, so the extra bit collects the carry and the language shift semantics
// give the behaviour at and beyond WIDTH without special cases.
// Assumes: kind is one of the three linear codes; other codes pass through.
module shift_linear
    import shift_unit_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int AMT_W = 8
) (
    input  shift_op_e          kind,
    input  logic [WIDTH-1:0]   operand,
    input  logic [AMT_W-1:0]   amount,
    input  logic               carry_in,
    output logic [WIDTH-1:0]   res,
    output logic               cout
);

    localparam int EXT_W = WIDTH + 1;

    logic [EXT_W-1:0]        left_ext;
    logic [EXT_W-1:0]        right_ext;
    logic signed [EXT_W-1:0] sign_src;
    logic signed [EXT_W-1:0] sign_ext;

    // Build the three extended shifts; the spare bit holds the carry.
    always_comb begin
        left_ext  = {1'b0, operand} << amount;
        right_ext = {operand, 1'b0} >> amount;
        sign_src  = {operand, 1'b0};
        sign_ext  = sign_src >>> amount;
    end

    // Choose the result and carry by kind; a zero count passes everything through.
    always_comb begin
        res  = operand;
        cout = carry_in;
        if (amount != '0) begin
            unique case (kind)
                SH_LSL: begin
                    res  = left_ext[WIDTH-1:0];
                    cout = left_ext[WIDTH];
                end
                SH_LSR: begin
                    res  = right_ext[WIDTH:1];
                    cout = right_ext[0];
                end
                SH_ASR: begin
                    res  = sign_ext[WIDTH:1];
                    cout = sign_ext[0];
                end
                default: begin
                    res  = operand;
                    cout = carry_in;
                end
            endcase
        end
    end

endmodule

// File: rtl/shift_rotate.sv
// Module: shift_rotate
// Handles rotate right (count taken modulo WIDTH) and the one-place rotate
// through the carry. Rotation takes the low half of a doubled operand after a
// right shift.
// Assumes: WIDTH is a power of two, so the low ROT_W count bits give the modulus.
module shift_rotate
    import shift_unit_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int AMT_W = 8
) (
    input  shift_op_e          kind,
    input  logic [WIDTH-1:0]   operand,
    input  logic [AMT_W-1:0]   amount,
    input  logic               carry_in,
    output logic [WIDTH-1:0]   res,
    output logic               cout
);

    localparam int ROT_W = $clog2(WIDTH);

    logic [ROT_W-1:0]   rot_cnt;
    logic [2*WIDTH-1:0] doubled;

    // Reduce the count and rotate the doubled operand.
    always_comb begin
        rot_cnt = amount[ROT_W-1:0];
        doubled = {operand, operand} >> rot_cnt;
    end

    // Pick the rotate or extended-rotate result and its carry.
    always_comb begin
        res  = operand;
        cout = carry_in;
        if (kind == SH_RRX) begin
            res  = {carry_in, operand[WIDTH-1:1]};
            cout = operand[0];
        end else if (kind == SH_ROR && amount != '0) begin
            res  = doubled[WIDTH-1:0];
            cout = doubled[WIDTH-1];
        end
    end

endmodule

// File: rtl/flag_next_logic.sv
// Module: flag_next_logic
// Works out the next condition flags from the shift result. Overflow always
// passes through; the other three update only when set_flags is high.
// Assumes: flags_in is the current architectural flag word.
module flag_next_logic
    import shift_unit_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic               set_flags,
    input  logic [WIDTH-1:0]   res,
    input  logic               shift_c,
    input  cc_flags_t          flags_in,
    output cc_flags_t          flags_out
);

    // Replace N, Z and C when writing is enabled; V is never written.
    always_comb begin
        flags_out = flags_in;
        if (set_flags) begin
            flags_out.n = res[WIDTH-1];
            flags_out.z = (res == '0);
            flags_out.c = shift_c;
        end
    end

endmodule

// File: rtl/shift_flag_unit.sv
// Module: shift_flag_unit (top)
// Combinational shift/rotate unit with a carry output and a next-flag word.
// There is an optional register stage (REG_FLAGS) that loads the flags when
// set_flags is high.
// Assumes: op_sel holds codes 0..4; codes 5..7 pass the operand and carry_in through.
module shift_flag_unit
    import shift_unit_pkg::*;
#(
    parameter int WIDTH     = 32,
    parameter int AMT_W     = 8,
    parameter bit REG_FLAGS = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_sel,
    input  logic [AMT_W-1:0]  amount,
    input  logic [WIDTH-1:0]  operand,
    input  logic              carry_in,
    input  logic              set_flags,
    input  logic [3:0]        flags_in,
    output logic [WIDTH-1:0]  result,
    output logic              shift_carry,
    output logic [3:0]        flags_next,
    output logic [3:0]        flags_q
);

    localparam int ROT_W = $clog2(WIDTH);

    shift_op_e        op_e;
    logic [WIDTH-1:0] lin_res;
    logic             lin_c;
    logic [WIDTH-1:0] rot_res;
    logic             rot_c;
    cc_flags_t        cur_flags;
    cc_flags_t        nxt_flags;

    assign op_e      = shift_op_e'(op_sel);
    assign cur_flags = cc_flags_t'(flags_in);

    shift_linear #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_linear (
        .kind     (op_e),
        .operand  (operand),
        .amount   (amount),
        .carry_in (carry_in),
        .res      (lin_res),
        .cout     (lin_c)
    );

    shift_rotate #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_rotate (
        .kind     (op_e),
        .operand  (operand),
        .amount   (amount),
        .carry_in (carry_in),
        .res      (rot_res),
        .cout     (rot_c)
    );

    // Route the linear or rotating datapath to the outputs.
    always_comb begin
        if (op_e == SH_ROR || op_e == SH_RRX) begin
            result      = rot_res;
            shift_carry = rot_c;
        end else begin
            result      = lin_res;
            shift_carry = lin_c;
        end
    end

    flag_next_logic #(.WIDTH(WIDTH)) u_flags (
        .set_flags (set_flags),
        .res       (result),
        .shift_c   (shift_carry),
        .flags_in  (cur_flags),
        .flags_out (nxt_flags)
    );

    assign flags_next = nxt_flags;

    generate
        if (REG_FLAGS) begin : g_flag_reg
            // Flag register: cleared by reset, loaded only when writing is enabled.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    flags_q <= '0;
                end else if (set_flags) begin
                    flags_q <= flags_next;
                end
            end

            AST_FLAGQ_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
                set_flags |=> flags_q == $past(flags_next)); // R10
            AST_FLAGQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                !set_flags |=> $stable(flags_q)); // R10
        end else begin : g_flag_wire
            assign flags_q = flags_next;
        end
    endgenerate

    AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (amount == '0 && op_sel <= 3'd3) |-> (result == operand && shift_carry == carry_in)); // R2
    AST_LOGIC_BEYOND: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_e == SH_LSL || op_e == SH_LSR) && amount > AMT_W'(WIDTH)) |-> (result == '0 && !shift_carry)); // R3
    AST_ASR_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == SH_ASR && amount >= AMT_W'(WIDTH)) |->
        (result == {WIDTH{operand[WIDTH-1]}} && shift_carry == operand[WIDTH-1])); // R4
    AST_ROR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == SH_ROR && amount != '0 && amount[ROT_W-1:0] == '0) |->
        (result == operand && shift_carry == operand[WIDTH-1])); // R5
    AST_RRX_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == SH_RRX) |-> (result[WIDTH-1] == carry_in && shift_carry == operand[0])); // R6
    AST_NZC_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_flags |-> (flags_next[3] == result[WIDTH-1] && flags_next[2] == (result == '0)
                       && flags_next[1] == shift_carry)); // R7
    AST_V_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        flags_next[0] == flags_in[0]); // R8
    AST_NO_SET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !set_flags |-> flags_next == flags_in); // R9

endmodule

// File: tb/shift_flag_unit_test.sv
// Directed bench for shift_flag_unit. A bit-serial model (one place per count)
// supplies the expected values.
module shift_flag_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_sel = 3'd0;
    logic [7:0]  amount = 8'd0;
    logic [31:0] operand = 32'd0;
    logic        carry_in = 1'b0;
    logic        set_flags = 1'b0;
    logic [3:0]  flags_in = 4'd0;
    logic [31:0] result;
    logic        shift_carry;
    logic [3:0]  flags_next;
    logic [3:0]  flags_q;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    shift_flag_unit uut (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .amount(amount),
        .operand(operand), .carry_in(carry_in), .set_flags(set_flags),
        .flags_in(flags_in), .result(result), .shift_carry(shift_carry),
        .flags_next(flags_next), .flags_q(flags_q)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Bit-serial model: one place per count, carry = last bit out.
    function automatic void model(input logic [2:0] op, input logic [31:0] x, input logic [7:0] a,
                                  input logic ci, output logic [31:0] r, output logic co);
        r  = x;
        co = ci;
        case (op)
            3'd0: for (int i = 0; i < a; i++) begin co = r[0];  r = {r[31], r[31:1]}; end
            3'd1: for (int i = 0; i < a; i++) begin co = r[31]; r = {r[30:0], 1'b0}; end
            3'd2: for (int i = 0; i < a; i++) begin co = r[0];  r = {1'b0, r[31:1]}; end
            3'd3: begin
                for (int i = 0; i < (a % 32); i++) r = {r[0], r[31:1]};
                if (a != 8'd0) co = r[31];
            end
            default: begin co = x[0]; r = {ci, x[31:1]}; end
        endcase
    endfunction

    // Apply one input set, then compare result, carry and next flags.
    task automatic run_case(input string req, input logic [2:0] op, input logic [31:0] x,
                            input logic [7:0] a, input logic ci, input logic sf, input logic [3:0] fin);
        logic [31:0] er;
        logic        ec;
        logic [3:0]  ef;
        @(negedge clk);
        op_sel = op; operand = x; amount = a; carry_in = ci; set_flags = sf; flags_in = fin;
        #1;
        model(op, x, a, ci, er, ec);
        ef = sf ? {er[31], (er == 32'd0), ec, fin[0]} : fin;
        check(req, "result", result, er);
        check(req, "carry", {31'd0, shift_carry}, {31'd0, ec});
        check(req, "flags_next", {28'd0, flags_next}, {28'd0, ef});
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R10", "flags_q after reset", {28'd0, flags_q}, 32'd0);
    endtask

    task automatic t_zero_count;
        for (int op = 0; op < 4; op++) begin
            run_case("R2", 3'(op), 32'h8000_0001, 8'd0, 1'b1, 1'b1, 4'b0000);
            run_case("R2", 3'(op), 32'h1234_5678, 8'd0, 1'b0, 1'b1, 4'b0011);
        end
    endtask

    task automatic t_lsl;
        run_case("R1", 3'd1, 32'hF000_000F, 8'd1,  1'b0, 1'b1, 4'b0000);
        run_case("R1", 3'd1, 32'h0000_0001, 8'd31, 1'b0, 1'b1, 4'b0000);
        run_case("R1", 3'd1, 32'hA5A5_A5A5, 8'd4,  1'b1, 1'b1, 4'b0001);
    endtask

    task automatic t_lsr;
        run_case("R11", 3'd2, 32'hF000_000F, 8'd1,  1'b0, 1'b1, 4'b0000);
        run_case("R11", 3'd2, 32'h8000_0000, 8'd31, 1'b0, 1'b1, 4'b0000);
        run_case("R11", 3'd2, 32'h0000_0100, 8'd9,  1'b0, 1'b1, 4'b0000);
    endtask

    task automatic t_logic_edges;
        run_case("R3", 3'd1, 32'h0000_0001, 8'd32,  1'b0, 1'b1, 4'b0000);
        run_case("R3", 3'd2, 32'h8000_0000, 8'd32,  1'b0, 1'b1, 4'b0000);
        run_case("R3", 3'd1, 32'hFFFF_FFFF, 8'd33,  1'b1, 1'b1, 4'b0010);
        run_case("R3", 3'd2, 32'hFFFF_FFFF, 8'd33,  1'b1, 1'b1, 4'b0010);
        run_case("R3", 3'd1, 32'hFFFF_FFFF, 8'd255, 1'b1, 1'b1, 4'b0010);
    endtask

    task automatic t_asr;
        run_case("R4", 3'd0, 32'h8000_0010, 8'd4,   1'b0, 1'b1, 4'b0000);
        run_case("R4", 3'd0, 32'h7000_0008, 8'd4,   1'b0, 1'b1, 4'b0000);
        run_case("R4", 3'd0, 32'h8000_0000, 8'd32,  1'b0, 1'b1, 4'b0000);
        run_case("R4", 3'd0, 32'h7FFF_FFFF, 8'd32,  1'b1, 1'b1, 4'b0000);
        run_case("R4", 3'd0, 32'h9000_0000, 8'd200, 1'b0, 1'b1, 4'b0000);
    endtask

    task automatic t_ror;
        run_case("R5", 3'd3, 32'h0000_0001, 8'd1,   1'b0, 1'b1, 4'b0000);
        run_case("R5", 3'd3, 32'h1234_5678, 8'd4,   1'b0, 1'b1, 4'b0000);
        run_case("R5", 3'd3, 32'h8000_0001, 8'd32,  1'b0, 1'b1, 4'b0000);
        run_case("R5", 3'd3, 32'h0000_0001, 8'd64,  1'b1, 1'b1, 4'b0000);
        run_case("R5", 3'd3, 32'h1234_5678, 8'd36,  1'b0, 1'b1, 4'b0000);
    endtask

    task automatic t_rrx;
        run_case("R6", 3'd4, 32'h0000_0003, 8'd0,   1'b1, 1'b1, 4'b0000);
        run_case("R6", 3'd4, 32'h0000_0002, 8'd17,  1'b0, 1'b1, 4'b0000);
        run_case("R6", 3'd4, 32'h0000_0001, 8'd255, 1'b0, 1'b1, 4'b1111);
    endtask

    task automatic t_flag_bits;
        run_case("R7", 3'd2, 32'h0000_0001, 8'd1, 1'b0, 1'b1, 4'b1000);
        run_case("R7", 3'd1, 32'h4000_0000, 8'd1, 1'b0, 1'b1, 4'b0110);
        run_case("R8", 3'd1, 32'h7FFF_FFFF, 8'd1, 1'b0, 1'b1, 4'b0001);
        run_case("R8", 3'd0, 32'h8000_0000, 8'd40, 1'b0, 1'b1, 4'b0000);
    endtask

    task automatic t_no_set;
        run_case("R9", 3'd2, 32'h0000_0001, 8'd1, 1'b1, 1'b0, 4'b0101);
        run_case("R9", 3'd0, 32'h8000_0000, 8'd3, 1'b0, 1'b0, 4'b1010);
    endtask

    task automatic t_flag_reg;
        // Load: set_flags high, value appears after the edge.
        @(negedge clk);
        op_sel = 3'd2; operand = 32'h0000_0001; amount = 8'd1; carry_in = 1'b0;
        set_flags = 1'b1; flags_in = 4'b0001;
        @(posedge clk); #1;
        check("R10", "flags_q load", {28'd0, flags_q}, {28'd0, 4'b0111});
        // Hold: set_flags low with different flags_in.
        @(negedge clk);
        set_flags = 1'b0; flags_in = 4'b1000;
        @(posedge clk); #1;
        check("R10", "flags_q hold", {28'd0, flags_q}, {28'd0, 4'b0111});
        // Reset with set_flags high clears the register.
        @(negedge clk);
        rst_n = 1'b0; set_flags = 1'b1;
        @(posedge clk); #1;
        check("R10", "flags_q reset", {28'd0, flags_q}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1; set_flags = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        set_flags = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        t_zero_count();
        t_lsl();
        t_lsr();
        t_logic_edges();
        t_asr();
        t_ror();
        t_rrx();
        t_flag_bits();
        t_no_set();
        t_flag_reg();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule